// File: doc/BRIEF.md
# Character Row Overlay for a 640x480 Raster

This block paints a single row of text onto a live video raster without any frame memory. Each clock it receives the pixel coordinate and blanking flag produced by an external sync timing generator. It works out whether that pixel falls inside the text box, which character slot and which glyph row and column it belongs to. It then emits a 24-bit colour. The glyphs are recomputed for every pixel of every frame, so each scan line crossing the box draws the matching glyph row of every character in turn.

Character codes sit in a small register array that a keyboard path fills one slot at a time. Each code passes through a translation step that turns it into an index into a built-in 8x8 font. Codes with no glyph draw as an empty cell. The box sits at a fixed anchor set by parameters, so the same coordinates produce the same colour in every frame.

Top module: `text_overlay`

## Requirements
- R1: While rst_ni is low, pix_o is 0 and every character slot holds code 0.
- R2: Slot i covers x from ANCHOR_X+8i to ANCHOR_X+8i+7 and y from ANCHOR_Y to ANCHOR_Y+7. The glyph row is y-ANCHOR_Y and the glyph column is the low 3 bits of x-ANCHOR_X. Glyph row bit 7 is the leftmost pixel. A set bit gives FG_COLOR and a clear bit gives BG_COLOR.
- R3: A pixel coordinate and blanking flag sampled at one rising edge of clk_i determine pix_o from the second following rising edge onward, which is a latency of three register stages.
- R4: Codes '0'..'9' (0x30-0x39) and 'A'..'F' (0x41-0x46) have glyphs. 'a'..'f' (0x61-0x66) draw the same glyph as the matching upper-case letter. Every other code, including the empty value 0, draws a cell that is entirely BG_COLOR.
- R5: A pixel sampled with blank_i high gives pix_o = 0, wherever it lies.
- R6: A non-blanked pixel outside the text box gives pix_o = 0.
- R7: When wr_en_i is high at a rising edge and wr_idx_i < NUM_CHARS, wr_char_i replaces that slot. Pixels sampled from the next edge onward see the new code. A write with wr_idx_i >= NUM_CHARS changes no slot.
- R8: Slots keep their codes across frames, so identical coordinates give identical pixels in successive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| px_x_i | input | X_W | Current pixel column from the timing generator |
| px_y_i | input | Y_W | Current pixel line from the timing generator |
| blank_i | input | 1 | High outside the visible area |
| wr_en_i | input | 1 | Write strobe for a character slot |
| wr_idx_i | input | IDX_W | Slot number to write |
| wr_char_i | input | 8 | ASCII code to store |
| pix_o | output | 24 | Pixel colour, 8 bits each of red, green and blue |

## Verification
The embedded properties check the following on every cycle: a blanked or out-of-box pixel leaving the last stage becomes black, the output is always one of black, FG_COLOR or BG_COLOR, an in-range write lands in its slot, and an out-of-range write leaves the array untouched. Some behaviours can only be shown by the bench's scans against a behavioural model. These are the actual glyph shapes and their left-to-right bit order, the boundaries of the box in x and y, the folding of lower-case hex letters, the blank cells for unmapped and empty codes, the three-cycle alignment between coordinate and colour, and repeatability between frames.

// File: rtl/text_overlay_pkg.sv
package text_overlay_pkg;
  localparam int GIDX_W = 5;
  localparam int CODE_W = 8;
  typedef logic [GIDX_W-1:0] gidx_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [23:0]       rgb_t;
  typedef logic [63:0]       glyph_t;  // row 0 in bits 63:56, bit 7 of a row = leftmost
endpackage

// File: rtl/tov_char_store.sv
module tov_char_store
  import text_overlay_pkg::*;
#(
  parameter int NUM_CHARS = 12,
  localparam int IDX_W = $clog2(NUM_CHARS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  code_t                        wr_char_i,
  output logic [NUM_CHARS-1:0][CODE_W-1:0] chars_o
);
  localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(NUM_CHARS);

  logic [NUM_CHARS-1:0][CODE_W-1:0] chars_q;
  logic                             wr_ok;

  assign wr_ok = wr_en_i && ({1'b0, wr_idx_i} < N_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chars_q <= '0;
    else if (wr_ok) chars_q[wr_idx_i] <= wr_char_i;
  end

  assign chars_o = chars_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ({1'b0, wr_idx_i} < N_LIM)) |=> chars_q[$past(wr_idx_i)] == $past(wr_char_i)); // R7
  AST_OOR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ({1'b0, wr_idx_i} >= N_LIM)) |=> $stable(chars_q)); // R7
endmodule

// File: rtl/tov_glyph_map.sv
module tov_glyph_map
  import text_overlay_pkg::*;
(
  input  code_t code_i,
  output gidx_t gidx_o
);
  // 0 = empty cell, 1..10 = digits, 11..16 = hex letters
  always_comb begin
    gidx_o = '0;
    if (code_i >= 8'h30 && code_i <= 8'h39)      gidx_o = GIDX_W'(code_i - 8'h30 + 8'd1);
    else if (code_i >= 8'h41 && code_i <= 8'h46) gidx_o = GIDX_W'(code_i - 8'h41 + 8'd11);
    else if (code_i >= 8'h61 && code_i <= 8'h66) gidx_o = GIDX_W'(code_i - 8'h61 + 8'd11);
  end
endmodule

// File: rtl/tov_glyph_rom.sv
module tov_glyph_rom
  import text_overlay_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  gidx_t      gidx_i,
  input  logic [2:0] row_i,
  output logic [7:0] bits_o
);
  function automatic glyph_t font(gidx_t g);
    case (g)
      5'd1:  return 64'h3C666E7666663C00;
      5'd2:  return 64'h1838181818187E00;
      5'd3:  return 64'h3C66060C30607E00;
      5'd4:  return 64'h3C66061C06663C00;
      5'd5:  return 64'h0C1C2C4C7E0C0C00;
      5'd6:  return 64'h7E607C0606663C00;
      5'd7:  return 64'h3C607C6666663C00;
      5'd8:  return 64'h7E060C1830303000;
      5'd9:  return 64'h3C66663C66663C00;
      5'd10: return 64'h3C66663E060C3800;
      5'd11: return 64'h183C66667E666600;
      5'd12: return 64'h7C66667C66667C00;
      5'd13: return 64'h3C66606060663C00;
      5'd14: return 64'h786C6666666C7800;
      5'd15: return 64'h7E60607860607E00;
      5'd16: return 64'h7E60607860606000;
      default: return 64'h0;
    endcase
  endfunction

  glyph_t     g;
  logic [2:0] inv_row;

  assign g       = font(gidx_i);
  assign inv_row = ~row_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= g[{inv_row, 3'b000} +: 8];
  end
endmodule

// File: rtl/text_overlay.sv
module text_overlay
  import text_overlay_pkg::*;
#(
  parameter int   X_W       = 10,
  parameter int   Y_W       = 10,
  parameter int   NUM_CHARS = 12,
  parameter int   ANCHOR_X  = 64,
  parameter int   ANCHOR_Y  = 32,
  parameter rgb_t FG_COLOR  = 24'hFFFFFF,
  parameter rgb_t BG_COLOR  = 24'h000080,
  localparam int  IDX_W     = $clog2(NUM_CHARS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [X_W-1:0]   px_x_i,
  input  logic [Y_W-1:0]   px_y_i,
  input  logic             blank_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_char_i,
  output logic [23:0]      pix_o
);
  localparam logic [X_W:0] X_LO = (X_W+1)'(ANCHOR_X);
  localparam logic [X_W:0] X_HI = (X_W+1)'(ANCHOR_X + 8*NUM_CHARS);
  localparam logic [Y_W:0] Y_LO = (Y_W+1)'(ANCHOR_Y);
  localparam logic [Y_W:0] Y_HI = (Y_W+1)'(ANCHOR_Y + 8);

  logic [NUM_CHARS-1:0][CODE_W-1:0] chars;

  tov_char_store #(.NUM_CHARS(NUM_CHARS)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_char_i, .chars_o(chars)
  );

  // stage 0: locate pixel inside the box
  logic           in_win;
  logic [X_W-1:0] rel_x, slot;
  logic [2:0]     row, col;
  code_t          cur_code;
  gidx_t          cur_gidx;

  assign in_win = ({1'b0, px_x_i} >= X_LO) && ({1'b0, px_x_i} < X_HI) &&
                  ({1'b0, px_y_i} >= Y_LO) && ({1'b0, px_y_i} < Y_HI);
  assign rel_x  = px_x_i - X_LO[X_W-1:0];
  assign slot   = rel_x >> 3;
  assign col    = rel_x[2:0];
  assign row    = 3'(px_y_i - Y_LO[Y_W-1:0]);

  always_comb begin
    cur_code = '0;
    for (int i = 0; i < NUM_CHARS; i++)
      if (in_win && slot == X_W'(i)) cur_code = chars[i];
  end

  tov_glyph_map i_map (.code_i(cur_code), .gidx_o(cur_gidx));

  // stage 1
  gidx_t      gidx_q1;
  logic [2:0] row_q1, col_q1;
  logic       win_q1, blank_q1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gidx_q1 <= '0; row_q1 <= '0; col_q1 <= '0; win_q1 <= 1'b0; blank_q1 <= 1'b1;
    end else begin
      gidx_q1 <= cur_gidx; row_q1 <= row; col_q1 <= col;
      win_q1  <= in_win;   blank_q1 <= blank_i;
    end
  end

  // stage 2: glyph row read, side signals delayed to match
  logic [7:0] bits_q2;
  logic [2:0] col_q2;
  logic       win_q2, blank_q2;

  tov_glyph_rom i_rom (
    .clk_i, .rst_ni, .gidx_i(gidx_q1), .row_i(row_q1), .bits_o(bits_q2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q2 <= '0; win_q2 <= 1'b0; blank_q2 <= 1'b1;
    end else begin
      col_q2 <= col_q1; win_q2 <= win_q1; blank_q2 <= blank_q1;
    end
  end

  // stage 3: colour select
  logic glyph_bit;
  assign glyph_bit = bits_q2[~col_q2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pix_o <= '0;
    else if (blank_q2 || !win_q2) pix_o <= '0;
    else                        pix_o <= glyph_bit ? FG_COLOR : BG_COLOR;
  end

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q2 |=> pix_o == '0); // R5
  AST_OUTSIDE_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_q2 |=> pix_o == '0); // R6
  AST_COLOR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == '0) || (pix_o == FG_COLOR) || (pix_o == BG_COLOR)); // R2
endmodule

// File: tb/test_text_overlay.sv
module test_text_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;
  localparam int AX = 64;
  localparam int AY = 32;
  localparam logic [23:0] FG = 24'hFFFFFF;
  localparam logic [23:0] BG = 24'h000080;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  px_x = '0, px_y = '0;
  logic        blank = 1'b1, wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [7:0]  wr_char = '0;
  logic [23:0] pix_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [7:0] model [NCH];
  logic [23:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  text_overlay i_text_overlay (
    .clk_i(clk), .rst_ni, .px_x_i(px_x), .px_y_i(px_y), .blank_i(blank),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_char_i(wr_char), .pix_o
  );

  function automatic logic [63:0] ref_font(logic [7:0] c);
    case (c)
      "0":      return 64'h3C666E7666663C00;
      "1":      return 64'h1838181818187E00;
      "A", "a": return 64'h183C66667E666600;
      "F", "f": return 64'h7E60607860606000;
      default:  return 64'h0;
    endcase
  endfunction

  task automatic check(logic [23:0] act, logic [23:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pix_o=%h expected %h", tag, act, exp);
    end
  endtask

  // one pixel clock: compare the oldest pending result, then present new inputs (R3)
  task automatic step(int x, int y, bit bl, bit we, int idx, logic [7:0] ch, int frame);
    logic [23:0] e;
    string t;
    @(negedge clk);
    if (exp_q.size() == 3) check(pix_o, exp_q.pop_front(), tag_q.pop_front());
    px_x = 10'(x); px_y = 10'(y); blank = bl;
    wr_en = we; wr_idx = 4'(idx); wr_char = ch;
    if (bl) begin
      e = '0; t = "R5 R3";
    end else if (x < AX || x >= AX + 8*NCH || y < AY || y >= AY + 8) begin
      e = '0; t = "R6 R3";
    end else begin
      int s = (x - AX) / 8;
      logic [63:0] g = ref_font(model[s]);
      e = g[63 - 8*(y - AY) - ((x - AX) % 8)] ? FG : BG;
      t = (g == 0) ? "R4" : "R2 R3";
      if (model[s] inside {"a", "f"}) t = {t, " R4"};
      if (s == NCH - 1) t = {t, " R7"};
      if (frame == 2) t = {t, " R8"};
    end
    exp_q.push_back(e); tag_q.push_back(t);
    if (we && idx < NCH) model[idx] = ch;
  endtask

  task automatic scan(int frame);
    for (int y = AY - 2; y <= AY + 9; y++)
      for (int x = AX - 3; x <= AX + 8*NCH + 2; x++)
        step(x, y, ((x + 3*y) % 29) == 0, 1'b0, 0, 8'h0, frame);
  endtask

  task automatic put(int idx, logic [7:0] ch);
    step(0, 0, 1'b1, 1'b1, idx, ch, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    string s1;
    for (int i = 0; i < NCH; i++) model[i] = 8'h0;
    // R1: reset holds output black
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pix_o, 24'h0, "R1");
    end
    @(negedge clk) rst_ni = 1'b1;
    // R1: empty slots after reset draw blank cells
    for (int x = AX; x < AX + 16; x++) step(x, AY + 3, 1'b0, 1'b0, 0, 8'h0, 0);
    s1 = "01AaF Z1f#0";
    for (int i = 0; i < s1.len(); i++) put(i, s1[i]);
    scan(1);
    // R7: out-of-range writes must not disturb slots; last slot written
    put(12, "A"); put(13, "1"); put(15, "0");
    put(NCH - 1, "1");
    scan(2);
    // far corners of the raster
    step(639, 479, 1'b0, 1'b0, 0, 8'h0, 0);
    step(0, 0, 1'b0, 1'b0, 0, 8'h0, 0);
    step(AX, AY, 1'b1, 1'b0, 0, 8'h0, 0);
    step(AX + 1, AY + 1, 1'b0, 1'b0, 0, 8'h0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1'b1, 1'b0, 0, 8'h0, 0);
    finish_run();
  end
endmodule